// File: doc/BRIEF.md
# Reset Cause Controller

This block gathers every reason the chip may need to be reset and turns them into one internal system reset. The sources are an active-low external reset pin, a supply-level monitor, a missing-clock detector, an analog comparator, a watchdog timeout, an illegal flash access and a software request. The monitor, comparator and clock detector arrive as asynchronous digital levels. The watchdog pulse and the flash access request are synchronous to `clk_i`.

The controller holds one software-visible byte, the cause register, at address 0. Writing it arms the supply, clock-detector and comparator sources and can trigger a software reset. Reading it returns a one-hot flag naming the source that caused the most recent reset. A second byte at address 1 holds the supply monitor enable. Each reset is stretched to a programmable minimum length and is released on a clock edge. Only a supply-monitor reset asks for the external pin to be pulled low.

Top module: `rst_cause_ctrl`

## Requirements
- R1: `sys_rst_o` rises on the clock edge that sees a reset request while idle, and it stays high for at least MIN_CYC cycles (default 16). A single-cycle request gives exactly MIN_CYC cycles.
- R2: The cause byte uses these bit positions: 0 pin, 1 supply, 2 clock detector, 3 comparator, 4 watchdog, 5 flash, 6 software, 7 always 0. Exactly one flag is set after any reset and all the others are cleared. When several requests arrive on the same edge, the lowest bit position wins.
- R3: The pin input passes through a two-flop synchronizer. A low lasting FILT_CYC (2) cycles or more resets the chip and sets bit 0. The reset is held for as long as the pin stays low. A low lasting one cycle is ignored.
- R4: The supply source is armed by writing bit 1 of address 0 only if monitor enable (address 1, bit 0) was already set. A write made while the monitor is disabled has no effect. Once armed, `supply_low_i` high resets the chip, sets bit 1 and holds the reset while it stays high. `pin_drv_o` is high during this reset.
- R5: Writing 1 to bit 2 of address 0 arms the clock detector and writing 0 disarms it. While it is armed, `clk_lost_i` high resets the chip and sets bit 2.
- R6: Writing 1 to bit 3 arms the comparator. While it is armed, `cmp_out_i` low resets the chip, sets bit 3 and holds the reset while it stays low. While it is not armed, the comparator has no effect.
- R7: A one-cycle `wdt_expire_i` pulse resets the chip and sets bit 4.
- R8: A flash request resets the chip and sets bit 5 when `fl_addr_i` is above USER_TOP or `fl_blocked_i` is high. A request at or below USER_TOP that is not blocked causes no reset.
- R9: Writing 1 to bit 6 of address 0 resets the chip and sets bit 6.
- R10: `pin_drv_o` is never high for a reset whose cause is anything other than the supply monitor.
- R11: While `sys_rst_o` is high, new requests and register writes are ignored, and the cause byte does not change.
- R12: Release happens on a clock edge, and only once the minimum length has passed and no held condition (pin, supply, clock detector, comparator) remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_ni | input | 1 | External reset pin level, active low, asynchronous |
| supply_low_i | input | 1 | Supply monitor reports low supply, asynchronous |
| clk_lost_i | input | 1 | Missing-clock one-shot has timed out, asynchronous |
| cmp_out_i | input | 1 | Comparator output, low requests reset, asynchronous |
| wdt_expire_i | input | 1 | Watchdog timeout pulse, synchronous |
| fl_req_i | input | 1 | Flash access (read, write, erase or fetch) valid this cycle |
| fl_addr_i | input | ADDR_W | Flash access address |
| fl_blocked_i | input | 1 | Access is refused by the security setting |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 cause/arm, 1 monitor enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sys_rst_o | output | 1 | Internal system reset, active high |
| pin_drv_o | output | 1 | Request to pull the external pin low |

## Verification
The hardest cases to reach are a source that stays active past the minimum stretch, and any activity that happens while a reset is already running. The bench reaches the first by keeping the pin, comparator or supply level asserted in a parallel thread for a fixed number of cycles while the main thread measures the reset length. It reaches the second by launching a software reset and then, a few cycles into it, writing a comparator arm and pulsing the watchdog. It then shows through the cause byte and a later comparator low that both were dropped. For same-edge priority, the watchdog, a bad flash request and a software write are driven on the same negative edge.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned NSRC  = 7;
  localparam int unsigned REG_W = 8;

  typedef enum int unsigned {
    SRC_PIN = 0, SRC_SUP = 1, SRC_CLK = 2, SRC_CMP = 3,
    SRC_WDT = 4, SRC_FLS = 5, SRC_SW = 6
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;

  // lowest index wins
  function automatic src_vec_t pick_first(src_vec_t v);
    src_vec_t r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/pin_filter.sv
module pin_filter #(
  parameter int unsigned FILT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic low_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (pin_n_i)    cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign low_o = (cnt_q == LIM);
endmodule

// File: rtl/flash_chk.sv
module flash_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter logic [ADDR_W-1:0] USER_TOP = 14'h1DFF
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              blocked_i,
  output logic              err_o
);
  logic out_of_range;
  assign out_of_range = (addr_i > USER_TOP);
  assign err_o = req_i && (out_of_range || blocked_i);
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rcc_pkg::*;
#(
  parameter int unsigned MIN_CYC = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t req_i,
  input  logic     hold_i,
  output logic     sys_rst_o,
  output src_vec_t cause_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;
  src_vec_t      cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      cause_q <= '0;
    end else if (!act_q) begin
      if (|req_i) begin
        act_q   <= 1'b1;
        cnt_q   <= '0;
        cause_q <= pick_first(req_i);
      end
    end else if (cnt_q < LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (!hold_i) begin
      act_q <= 1'b0;
    end
  end

  assign sys_rst_o = act_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter logic [ADDR_W-1:0] USER_TOP = 14'h1DFF,
  parameter int unsigned MIN_CYC  = 16,
  parameter int unsigned FILT_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_rst_ni,
  input  logic              supply_low_i,
  input  logic              clk_lost_i,
  input  logic              cmp_out_i,
  input  logic              wdt_expire_i,
  input  logic              fl_req_i,
  input  logic [ADDR_W-1:0] fl_addr_i,
  input  logic              fl_blocked_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              sys_rst_o,
  output logic              pin_drv_o
);
  // async level order: {clk_lost, cmp, supply_low, pin_n}
  logic [3:0] async_s;
  logic       pin_low, fls_err;
  logic       mon_en_q, sup_en_q, clk_en_q, cmp_en_q;
  logic       lv_pin, lv_sup, lv_clk, lv_cmp, sw_req, hold;
  logic       wr_cause, wr_mon;
  src_vec_t   req, cause;

  sync_2ff #(.W(4), .RST_VAL(4'b0101)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({clk_lost_i, cmp_out_i, supply_low_i, pin_rst_ni}),
    .q_o   (async_s)
  );

  pin_filter #(.FILT_CYC(FILT_CYC)) i_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_n_i(async_s[0]),
    .low_o  (pin_low)
  );

  flash_chk #(.ADDR_W(ADDR_W), .USER_TOP(USER_TOP)) i_fchk (
    .req_i    (fl_req_i),
    .addr_i   (fl_addr_i),
    .blocked_i(fl_blocked_i),
    .err_o    (fls_err)
  );

  // writes are dropped while the chip is held in reset
  assign wr_cause = reg_wr_i && !reg_addr_i && !sys_rst_o;
  assign wr_mon   = reg_wr_i &&  reg_addr_i && !sys_rst_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_en_q <= 1'b0;
      sup_en_q <= 1'b0;
      clk_en_q <= 1'b0;
      cmp_en_q <= 1'b0;
    end else begin
      if (wr_mon) mon_en_q <= reg_wdata_i[0];
      if (wr_cause) begin
        if (mon_en_q) sup_en_q <= reg_wdata_i[SRC_SUP];
        clk_en_q <= reg_wdata_i[SRC_CLK];
        cmp_en_q <= reg_wdata_i[SRC_CMP];
      end
    end
  end

  assign lv_pin = pin_low;
  assign lv_sup = mon_en_q && sup_en_q && async_s[1];
  assign lv_cmp = cmp_en_q && !async_s[2];
  assign lv_clk = clk_en_q && async_s[3];
  assign sw_req = wr_cause && reg_wdata_i[SRC_SW];
  assign hold   = lv_pin || lv_sup || lv_clk || lv_cmp;

  always_comb begin
    req          = '0;
    req[SRC_PIN] = lv_pin;
    req[SRC_SUP] = lv_sup;
    req[SRC_CLK] = lv_clk;
    req[SRC_CMP] = lv_cmp;
    req[SRC_WDT] = wdt_expire_i;
    req[SRC_FLS] = fls_err;
    req[SRC_SW]  = sw_req;
  end

  rst_seq #(.MIN_CYC(MIN_CYC)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .hold_i   (hold),
    .sys_rst_o(sys_rst_o),
    .cause_o  (cause)
  );

  assign reg_rdata_o = reg_addr_i ? {7'b0, mon_en_q} : {{(REG_W-NSRC){1'b0}}, cause};
  assign pin_drv_o   = sys_rst_o && cause[SRC_SUP];
endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk
  import rcc_pkg::*;
#(
  parameter int unsigned MIN_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_rst_o,
  input logic       pin_drv_o,
  input src_vec_t   cause,
  input logic       hold,
  input logic       fls_err,
  input logic       reg_wr_i,
  input logic       reg_addr_i,
  input logic [7:0] reg_wdata_i
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= 0;
    else if (sys_rst_o) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= 0;
  end

  p_min_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && hi_cnt != 0) |-> hi_cnt >= MIN_CYC);

  p_one_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> $countones(cause) == 1);

  p_cause_onehot0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause));

  p_flash_fires_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && fls_err) |=> sys_rst_o);

  p_sw_fires_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && reg_wr_i && !reg_addr_i && reg_wdata_i[SRC_SW]) |=> sys_rst_o);

  p_pin_drv_sup_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drv_o |-> (sys_rst_o && cause[SRC_SUP]));

  p_cause_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && $past(sys_rst_o)) |-> $stable(cause));

  p_hold_keeps_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && hold) |=> sys_rst_o);
endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(.MIN_CYC(MIN_CYC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_rst_o  (sys_rst_o),
  .pin_drv_o  (pin_drv_o),
  .cause      (cause),
  .hold       (hold),
  .fls_err    (fls_err),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i)
);

// File: tb/test_rst_cause_ctrl.sv
`timescale 1ns/1ps
module test_rst_cause_ctrl;
  localparam int ADDR_W = 14;
  localparam logic [ADDR_W-1:0] USER_TOP = 14'h1DFF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pin_rst_ni = 1'b1, supply_low = 1'b0, clk_lost = 1'b0, cmp_out = 1'b1;
  logic wdt = 1'b0, fl_req = 1'b0, fl_blocked = 1'b0;
  logic [ADDR_W-1:0] fl_addr = '0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sys_rst, pin_drv;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_cause_ctrl #(.ADDR_W(ADDR_W), .USER_TOP(USER_TOP)) i_rst_cause_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pin_rst_ni(pin_rst_ni),
    .supply_low_i(supply_low), .clk_lost_i(clk_lost), .cmp_out_i(cmp_out),
    .wdt_expire_i(wdt), .fl_req_i(fl_req), .fl_addr_i(fl_addr),
    .fl_blocked_i(fl_blocked), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sys_rst_o(sys_rst), .pin_drv_o(pin_drv)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ge(string tag, int act, int lo);
    checks++;
    if (act < lo) begin
      fails++;
      $display("FAIL %s: actual %0d expected >= %0d", tag, act, lo);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 1'b0;
  endtask

  // from a negedge: wait up to 12 cycles for reset, then count high cycles
  task automatic wait_rst(output int len, output bit drv);
    int t = 0;
    len = 0; drv = 1'b0;
    while (!sys_rst && t < 12) begin @(negedge clk); t++; end
    while (sys_rst) begin
      len++;
      if (pin_drv) drv = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    @(negedge clk);
    rd(1'b0, d); chk("R2 cause after power-on", d, 8'h00);
    rd(1'b1, d); chk("R4 monitor enable after power-on", d, 8'h00);
    chk("R1 sys_rst idle", sys_rst, 0);
    chk("R10 pin_drv idle", pin_drv, 0);
  endtask

  task automatic t_sw;
    int len; bit drv; logic [7:0] d;
    wr(1'b0, 8'h40);
    wait_rst(len, drv);
    chk("R1 sw reset length", len, 16);
    rd(1'b0, d); chk("R9 sw cause", d, 8'h40);
    chk("R10 sw no pin drive", drv, 0);
  endtask

  task automatic t_wdt;
    int len; bit drv; logic [7:0] d;
    @(negedge clk); wdt = 1'b1;
    @(negedge clk); wdt = 1'b0;
    wait_rst(len, drv);
    chk("R1 wdt reset length", len, 16);
    rd(1'b0, d); chk("R7 wdt cause", d, 8'h10);
    chk("R10 wdt no pin drive", drv, 0);
  endtask

  task automatic flash_try(input logic [ADDR_W-1:0] a, input logic blk,
                           output int len, output bit drv);
    @(negedge clk); fl_req = 1'b1; fl_addr = a; fl_blocked = blk;
    @(negedge clk); fl_req = 1'b0; fl_blocked = 1'b0;
    wait_rst(len, drv);
  endtask

  task automatic t_flash;
    int len; bit drv; logic [7:0] d;
    flash_try(USER_TOP + 1'b1, 1'b0, len, drv);
    chk("R8 flash above top resets", len, 16);
    rd(1'b0, d); chk("R8 flash cause", d, 8'h20);
    chk("R10 flash no pin drive", drv, 0);
    wr(1'b0, 8'h40); wait_rst(len, drv);
    flash_try(USER_TOP, 1'b0, len, drv);
    chk("R8 flash at top no reset", len, 0);
    rd(1'b0, d); chk("R8 cause kept after legal access", d, 8'h40);
    flash_try('0, 1'b1, len, drv);
    chk("R8 blocked access resets", len, 16);
    rd(1'b0, d); chk("R8 blocked cause", d, 8'h20);
  endtask

  task automatic t_pin;
    int len; bit drv; logic [7:0] d;
    @(negedge clk); pin_rst_ni = 1'b0;
    @(negedge clk); pin_rst_ni = 1'b1;
    wait_rst(len, drv);
    chk("R3 one-cycle glitch ignored", len, 0);
    @(negedge clk); pin_rst_ni = 1'b0;
    fork
      begin repeat (40) @(negedge clk); pin_rst_ni = 1'b1; end
      wait_rst(len, drv);
    join
    chk_ge("R3 reset held while pin low", len, 36);
    rd(1'b0, d); chk("R3 pin cause", d, 8'h01);
    chk("R10 pin reset no pin drive", drv, 0);
  endtask

  task automatic t_cmp;
    int len; bit drv; logic [7:0] d;
    @(negedge clk); cmp_out = 1'b0;
    repeat (2) @(negedge clk);
    wait_rst(len, drv);
    cmp_out = 1'b1;
    chk("R6 comparator unarmed no reset", len, 0);
    wr(1'b0, 8'h08);
    @(negedge clk); cmp_out = 1'b0;
    fork
      begin repeat (30) @(negedge clk); cmp_out = 1'b1; end
      wait_rst(len, drv);
    join
    chk_ge("R12 held while comparator low", len, 26);
    rd(1'b0, d); chk("R6 comparator cause", d, 8'h08);
    chk("R10 comparator no pin drive", drv, 0);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_clk;
    int len; bit drv; logic [7:0] d;
    wr(1'b0, 8'h04);
    @(negedge clk); clk_lost = 1'b1;
    repeat (3) @(negedge clk); clk_lost = 1'b0;
    wait_rst(len, drv);
    chk("R5 clock loss reset length", len, 16);
    rd(1'b0, d); chk("R5 clock cause", d, 8'h04);
    chk("R10 clock loss no pin drive", drv, 0);
    wr(1'b0, 8'h00);
    @(negedge clk); clk_lost = 1'b1;
    repeat (3) @(negedge clk); clk_lost = 1'b0;
    wait_rst(len, drv);
    chk("R5 disarmed clock detector no reset", len, 0);
  endtask

  task automatic t_sup;
    int len; bit drv; logic [7:0] d;
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R4 monitor enable reads back", d, 8'h01);
    @(negedge clk); supply_low = 1'b1;
    repeat (2) @(negedge clk);
    wait_rst(len, drv);
    supply_low = 1'b0;
    chk("R4 arm before monitor enable ignored", len, 0);
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h02);
    @(negedge clk); supply_low = 1'b1;
    fork
      begin repeat (25) @(negedge clk); supply_low = 1'b0; end
      wait_rst(len, drv);
    join
    chk_ge("R4 supply reset held", len, 21);
    rd(1'b0, d); chk("R4 supply cause", d, 8'h02);
    chk("R4 supply reset drives pin", drv, 1);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_prio;
    int len; bit drv; logic [7:0] d;
    @(negedge clk);
    wdt = 1'b1; fl_req = 1'b1; fl_addr = '1;
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h40;
    @(negedge clk);
    wdt = 1'b0; fl_req = 1'b0; reg_wr = 1'b0;
    wait_rst(len, drv);
    rd(1'b0, d); chk("R2 wdt beats flash and sw", d, 8'h10);
    @(negedge clk);
    fl_req = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h40;
    @(negedge clk);
    fl_req = 1'b0; reg_wr = 1'b0;
    wait_rst(len, drv);
    rd(1'b0, d); chk("R2 flash beats sw", d, 8'h20);
  endtask

  task automatic t_busy;
    int len; bit drv; logic [7:0] d;
    wr(1'b0, 8'h40);
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'h08; wdt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; wdt = 1'b0;
    wait_rst(len, drv);
    rd(1'b0, d); chk("R11 cause unchanged by mid-reset events", d, 8'h40);
    @(negedge clk); cmp_out = 1'b0;
    repeat (2) @(negedge clk);
    wait_rst(len, drv);
    cmp_out = 1'b1;
    chk("R11 write during reset dropped", len, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_sw();
    t_wdt();
    t_flash();
    t_pin();
    t_cmp();
    t_clk();
    t_sup();
    t_prio();
    t_busy();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule